// File: doc/BRIEF.md
# MSB-Based Product Significance Filter

This block forms one approximate 3x3 dot product between nine signed activations and nine signed kernel weights. It does not multiply every pair. First it estimates the size of each product without multiplying: it takes the bit position of the leading one in each operand's magnitude, which is the integer part of its base-2 logarithm, and adds the two positions. It then finds the largest estimate in the window. Only the terms whose estimate lies close enough to that peak are multiplied and accumulated. Every other term counts as zero, so small non-zero products are dropped along with exact zeros.

The kernel's leading-one positions are computed once, when the kernel is loaded, and are supplied alongside the weights. The activations' positions are computed inside the block. A single strobe starts a window, and the block accepts a new window on every cycle. For each window it returns three results:
- the approximate sum, as a 64-bit signed value;
- a per-term mask of the products actually computed, which is fit to drive multiplier clock gating;
- a one-cycle done pulse.

Top module: `msb_sig_filter`

## Requirements
- R1: The magnitude proxy of an operand is the bit index of the highest set bit of its absolute value, taken as an unsigned 32-bit value. A negative operand is negated in two's complement first, so -2^31 yields 31.
- R2: The size estimate of term k is the activation's leading-one index plus the weight position given for term k on wgt_pos_i (5 bits per term, term k at bits [5k+4:5k]). The weight position is used exactly as supplied and is never recomputed from the weight value.
- R3: A term whose activation or weight is zero is never computed. Its mask bit is 0 and its estimate takes no part in finding the peak.
- R4: A live term is kept when (peak estimate − its estimate) ≤ thr_i. With thr_i = 0, only the terms that tie the peak are kept. The peak term of a window with any live term is always kept.
- R5: With thr_i = 63, every live term is kept and sum_o equals the exact dot product.
- R6: When no term is kept, sum_o is 0 and mask_o is 0.
- R7: sum_o is the two's-complement sum, modulo 2^64, of the full 64-bit signed products of the kept terms. There is no saturation.
- R8: done_o rises for one cycle, three rising clock edges after the edge that samples start_i. Windows may be started on consecutive cycles, and each one yields its own done pulse.
- R9: After reset, sum_o, mask_o and done_o are 0. sum_o and mask_o change only in a cycle in which done_o is high, and hold their values otherwise. In mask_o, bit k belongs to term k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins one window with the operands present |
| act_i | input | 288 | Nine signed activations, term k at [32k+31:32k] |
| wgt_i | input | 288 | Nine signed weights, term k at [32k+31:32k] |
| wgt_pos_i | input | 45 | Precomputed leading-one index of each weight |
| thr_i | input | 6 | Allowed gap below the peak estimate |
| sum_o | output | 64 | Approximate sum of the kept products |
| mask_o | output | 9 | Terms multiplied in the last window |
| done_o | output | 1 | Result valid pulse |

## Verification
The bench builds the block with its default parameters: nine 32-bit terms, a 6-bit threshold and a 64-bit sum. At these defaults the largest possible estimate gap (62) sits below the largest threshold (63). This makes the exact-convolution limit and the 2^62-per-term wrap of the sum both reachable from the ports. Directed windows place estimates exactly at and one step beyond the threshold, feed the most negative operand, and use a kernel position that disagrees with its weight to show that the supplied position decides. A run of back-to-back random windows with mixed zeros and thresholds then exercises the pipelined path.

// File: rtl/sig_filter_pkg.sv
package sig_filter_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned TAPS   = 9;
  localparam int unsigned THR_W  = 6;
  localparam int unsigned ACC_W  = 64;
endpackage

// File: rtl/msb_locator.sv
module msb_locator #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned POS_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] op_i,
  output logic [POS_W-1:0]  pos_o,
  output logic              nz_o
);
  logic [DATA_W-1:0] mag;

  always_comb begin
    mag   = op_i[DATA_W-1] ? (~op_i + 1'b1) : op_i;
    pos_o = '0;
    for (int i = 0; i < DATA_W; i++)
      if (mag[i]) pos_o = POS_W'(i);
    nz_o = |op_i;
  end
endmodule

// File: rtl/max_tree.sv
module max_tree #(
  parameter int unsigned N = 9,
  parameter int unsigned W = 6
) (
  input  logic [W-1:0] est_i [N],
  output logic [W-1:0] max_o
);
  localparam int unsigned LEAVES = 1 << $clog2(N);

  logic [W-1:0] node [2*LEAVES-1];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < N) begin : g_used
      assign node[LEAVES-1+i] = est_i[i];
    end else begin : g_pad
      assign node[LEAVES-1+i] = '0;
    end
  end

  for (genvar n = 0; n < LEAVES-1; n++) begin : g_node
    assign node[n] = (node[2*n+1] > node[2*n+2]) ? node[2*n+1] : node[2*n+2];
  end

  assign max_o = node[0];
endmodule

// File: rtl/acc_sum.sv
module acc_sum #(
  parameter int unsigned N     = 9,
  parameter int unsigned ACC_W = 64
) (
  input  logic [ACC_W-1:0] term_i [N],
  output logic [ACC_W-1:0] sum_o
);
  always_comb begin
    sum_o = '0;
    for (int k = 0; k < N; k++) sum_o = sum_o + term_i[k];
  end
endmodule

// File: rtl/msb_sig_filter.sv
module msb_sig_filter #(
  parameter int unsigned DATA_W = sig_filter_pkg::DATA_W,
  parameter int unsigned TAPS   = sig_filter_pkg::TAPS,
  parameter int unsigned THR_W  = sig_filter_pkg::THR_W,
  parameter int unsigned ACC_W  = sig_filter_pkg::ACC_W,
  localparam int unsigned POS_W = $clog2(DATA_W)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [TAPS*DATA_W-1:0]  act_i,
  input  logic [TAPS*DATA_W-1:0]  wgt_i,
  input  logic [TAPS*POS_W-1:0]   wgt_pos_i,
  input  logic [THR_W-1:0]        thr_i,
  output logic [ACC_W-1:0]        sum_o,
  output logic [TAPS-1:0]         mask_o,
  output logic                    done_o
);
  localparam int unsigned EST_W = POS_W + 1;
  localparam int unsigned CMP_W = (EST_W > THR_W) ? EST_W : THR_W;
  localparam int unsigned EXT_W = ACC_W - DATA_W;

  // stage A: captured window
  logic [DATA_W-1:0] act_q [TAPS];
  logic [DATA_W-1:0] wgt_q [TAPS];
  logic [POS_W-1:0]  wpos_q [TAPS];
  logic [THR_W-1:0]  thr_q;
  logic              vld_a;

  // stage B: gated products
  logic [ACC_W-1:0]  prod_q [TAPS];
  logic [TAPS-1:0]   keep_q;
  logic              vld_b;

  logic [POS_W-1:0]  apos [TAPS];
  logic [TAPS-1:0]   anz;
  logic [EST_W-1:0]  est [TAPS];
  logic [EST_W-1:0]  peak;
  logic [TAPS-1:0]   keep;
  logic [ACC_W-1:0]  prod_c [TAPS];
  logic [ACC_W-1:0]  sum_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_a <= 1'b0;
      thr_q <= '0;
      for (int k = 0; k < TAPS; k++) begin
        act_q[k]  <= '0;
        wgt_q[k]  <= '0;
        wpos_q[k] <= '0;
      end
    end else begin
      vld_a <= start_i;
      if (start_i) begin
        thr_q <= thr_i;
        for (int k = 0; k < TAPS; k++) begin
          act_q[k]  <= act_i[k*DATA_W +: DATA_W];
          wgt_q[k]  <= wgt_i[k*DATA_W +: DATA_W];
          wpos_q[k] <= wgt_pos_i[k*POS_W +: POS_W];
        end
      end
    end
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_term
    logic live;
    logic [ACC_W-1:0] a_ext, w_ext;

    msb_locator #(.DATA_W(DATA_W), .POS_W(POS_W)) i_loc (
      .op_i  (act_q[k]),
      .pos_o (apos[k]),
      .nz_o  (anz[k])
    );

    assign live  = anz[k] & (|wgt_q[k]);
    // dead terms enter the peak search as 0, which never exceeds a live estimate
    assign est[k] = live ? (EST_W'(apos[k]) + EST_W'(wpos_q[k])) : '0;
    assign keep[k] = live & (CMP_W'(peak - est[k]) <= CMP_W'(thr_q));
    assign a_ext = {{EXT_W{act_q[k][DATA_W-1]}}, act_q[k]};
    assign w_ext = {{EXT_W{wgt_q[k][DATA_W-1]}}, wgt_q[k]};
    assign prod_c[k] = keep[k] ? (a_ext * w_ext) : '0;
  end

  max_tree #(.N(TAPS), .W(EST_W)) i_peak (
    .est_i (est),
    .max_o (peak)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_b  <= 1'b0;
      keep_q <= '0;
      for (int k = 0; k < TAPS; k++) prod_q[k] <= '0;
    end else begin
      vld_b  <= vld_a;
      keep_q <= keep;
      for (int k = 0; k < TAPS; k++) prod_q[k] <= prod_c[k];
    end
  end

  acc_sum #(.N(TAPS), .ACC_W(ACC_W)) i_sum (
    .term_i (prod_q),
    .sum_o  (sum_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      sum_o  <= '0;
      mask_o <= '0;
    end else begin
      done_o <= vld_b;
      if (vld_b) begin
        sum_o  <= sum_c;
        mask_o <= keep_q;
      end
    end
  end
endmodule

// File: rtl/sig_filter_chk.sv
module sig_filter_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAPS   = 9,
  parameter int unsigned THR_W  = 6,
  parameter int unsigned ACC_W  = 64,
  parameter int unsigned POS_W  = 5
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic [TAPS*DATA_W-1:0] act_i,
  input logic [TAPS*DATA_W-1:0] wgt_i,
  input logic [TAPS*POS_W-1:0]  wgt_pos_i,
  input logic [THR_W-1:0]       thr_i,
  input logic [ACC_W-1:0]       sum_o,
  input logic [TAPS-1:0]        mask_o,
  input logic                   done_o
);
  localparam bit WIDE_OK = ((1 << THR_W) - 1) >= 2 * (DATA_W - 1);

  logic [TAPS-1:0] live_in;
  logic            pos_any;

  always_comb begin
    for (int k = 0; k < TAPS; k++)
      live_in[k] = (|act_i[k*DATA_W +: DATA_W]) & (|wgt_i[k*DATA_W +: DATA_W]);
    pos_any = |wgt_pos_i;
  end

  // R8
  start_to_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ##3 done_o);

  // R8
  done_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i, 3));

  // R3
  zero_term_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((mask_o & ~$past(live_in, 3)) == '0));

  // R4
  peak_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ($past(live_in, 3) != '0)) |-> (mask_o != '0));

  // R5
  wide_thr_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (WIDE_OK && done_o && ($past(thr_i, 3) == {THR_W{1'b1}})) |-> (mask_o == $past(live_in, 3)));

  // R6
  empty_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (mask_o == '0)) |-> (sum_o == '0));

  // R9
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(sum_o) && $stable(mask_o)));
endmodule

bind msb_sig_filter sig_filter_chk #(
  .DATA_W(DATA_W), .TAPS(TAPS), .THR_W(THR_W), .ACC_W(ACC_W), .POS_W(POS_W)
) i_chk (.*);

// File: tb/test_msb_sig_filter.sv
`timescale 1ns/1ps
module test_msb_sig_filter;
  localparam int DW = 32;
  localparam int NT = 9;
  localparam int PW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NT*DW-1:0] act = '0;
  logic [NT*DW-1:0] wgt = '0;
  logic [NT*PW-1:0] wpos = '0;
  logic [5:0] thr = '0;
  logic [63:0] sum;
  logic [NT-1:0] mask;
  logic done;

  always #2.5 clk = ~clk;

  msb_sig_filter i_msb_sig_filter (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .act_i(act), .wgt_i(wgt),
    .wgt_pos_i(wpos), .thr_i(thr), .sum_o(sum), .mask_o(mask), .done_o(done)
  );

  typedef struct {
    logic [63:0]   sum;
    logic [NT-1:0] mask;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  logic [63:0]   last_sum = '0;
  logic [NT-1:0] last_mask = '0;

  logic signed [DW-1:0] ta [NT];
  logic signed [DW-1:0] tw [NT];
  logic [PW-1:0]        tp [NT];

  task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // R1: leading-one index of the magnitude, scanned from the top
  function automatic int lead_one(input logic [DW-1:0] v);
    logic [DW-1:0] m;
    m = v[DW-1] ? (~v + 1'b1) : v;
    for (int i = DW-1; i >= 0; i--) if (m[i]) return i;
    return 0;
  endfunction

  task automatic fill_pos();
    for (int k = 0; k < NT; k++) tp[k] = PW'(lead_one(tw[k]));
  endtask

  task automatic drive(input logic [5:0] t, input string tag);
    exp_t e;
    int est [NT];
    bit live [NT];
    int peak;
    peak = 0;
    for (int k = 0; k < NT; k++) begin
      live[k] = (ta[k] != 0) && (tw[k] != 0);
      est[k] = lead_one(ta[k]) + int'(tp[k]);
      if (live[k] && est[k] > peak) peak = est[k];
    end
    e.sum = '0;
    e.mask = '0;
    e.tag = tag;
    for (int k = 0; k < NT; k++)
      if (live[k] && (peak - est[k]) <= int'(t)) begin
        e.mask[k] = 1'b1;
        e.sum = e.sum + 64'(longint'(ta[k]) * longint'(tw[k]));
      end
    @(negedge clk);
    for (int k = 0; k < NT; k++) begin
      act[k*DW +: DW] = ta[k];
      wgt[k*DW +: DW] = tw[k];
      wpos[k*PW +: PW] = tp[k];
    end
    thr = t;
    start = 1'b1;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        check(1'b0, "R8 unexpected done", 64'(done), 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(sum == e.sum, {e.tag, " sum R7"}, sum, e.sum);
        check(mask == e.mask, {e.tag, " mask"}, 64'(mask), 64'(e.mask));
        last_sum = e.sum;
        last_mask = e.mask;
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    check(1'b0, "R8 watchdog", 64'(q.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(sum == 0, "R9 reset sum", sum, 0);
    check(mask == 0, "R9 reset mask", 64'(mask), 0);
    check(done == 0, "R9 reset done", 64'(done), 0);
    rst_n = 1'b1;
    idle(2);

    // R6: all zero window
    for (int k = 0; k < NT; k++) begin ta[k] = 0; tw[k] = 0; end
    fill_pos();
    drive(6'd5, "R6 all zero");
    idle(5);

    // R4: T=0 keeps ties only (acts 1..9, weight 1 -> terms 8,9 tie at 3)
    for (int k = 0; k < NT; k++) begin ta[k] = k + 1; tw[k] = 1; end
    fill_pos();
    drive(6'd0, "R4 thr zero ties");
    idle(5);

    // R4: gap boundary, act = 2^k, T=3 keeps k=5..8 -> sum 480
    for (int k = 0; k < NT; k++) begin ta[k] = 1 <<< k; tw[k] = 1; end
    fill_pos();
    drive(6'd3, "R4 gap boundary");
    idle(5);
    check(sum == 64'd480, "R4 boundary sum", sum, 64'd480);
    check(mask == 9'h1E0, "R4 boundary mask", 64'(mask), 64'h1E0);
    // R9: outputs held while idle
    idle(4);
    check(sum == last_sum, "R9 hold sum", sum, last_sum);
    check(mask == last_mask, "R9 hold mask", 64'(mask), 64'(last_mask));

    // R5: T=63 exact over mixed signs and magnitudes
    for (int k = 0; k < NT; k++) begin
      ta[k] = (k % 2 == 0) ? (32'sd1 <<< (3 * k)) : -(32'sd7 <<< k);
      tw[k] = (k % 3 == 0) ? -32'sd3 : (32'sd100000 + k);
    end
    fill_pos();
    drive(6'd63, "R5 exact");
    idle(5);

    // R1: most negative operand, leading-one index 31
    for (int k = 0; k < NT; k++) begin ta[k] = 1000; tw[k] = 1000; end
    ta[4] = 32'sh8000_0000;
    tw[4] = -32'sd1;
    fill_pos();
    drive(6'd2, "R1 most negative");
    idle(5);

    // R3: zero weight with a large claimed position is suppressed
    for (int k = 0; k < NT; k++) begin ta[k] = 16; tw[k] = 16; end
    ta[0] = 32'sh4000_0000;
    tw[0] = 0;
    fill_pos();
    tp[0] = 5'd31;
    drive(6'd0, "R3 zero weight");
    ta[2] = 0;
    drive(6'd0, "R3 zero act");
    idle(5);

    // R2: supplied weight position decides, not the weight value
    for (int k = 0; k < NT; k++) begin ta[k] = 256; tw[k] = 256; end
    tw[6] = 1;
    fill_pos();
    tp[6] = 5'd20;
    drive(6'd4, "R2 supplied position");
    idle(5);

    // R7: nine products of 2^62 wrap to 2^62
    for (int k = 0; k < NT; k++) begin ta[k] = 32'sh8000_0000; tw[k] = 32'sh8000_0000; end
    fill_pos();
    drive(6'd0, "R7 wrap");
    idle(5);
    check(sum == 64'h4000_0000_0000_0000, "R7 wrap value", sum, 64'h4000_0000_0000_0000);

    // R8: back-to-back random windows
    for (int n = 0; n < 40; n++) begin
      for (int k = 0; k < NT; k++) begin
        ta[k] = ($urandom % 4 == 0) ? 0 : ($signed($urandom) >>> ($urandom % 28));
        tw[k] = ($urandom % 5 == 0) ? 0 : ($signed($urandom) >>> ($urandom % 28));
      end
      fill_pos();
      drive(6'($urandom % 10), "R8 random stream");
    end
    idle(8);
    check(q.size() == 0, "R8 all windows done", 64'(q.size()), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule